// File: doc/BRIEF.md
# Reservation-Tracking Shared Word Memory

This block is a small on-chip word memory shared by several processor ports, with hardware support for optimistic atomic sequences built from a load-reserved (LL) and a store-conditional (SC). Each port issues one of five operations: plain load, plain store, LL, SC and line-zero. An LL returns a word and arms a reservation on the aligned granule that contains it. A later SC from the same port commits only if that reservation is still armed and covers the SC address. A failed SC leaves memory untouched and reports failure, and software retries the sequence.

The memory has a single write path. A fixed-priority arbiter grants at most one port per cycle, starting from the lowest index. A separate external-agent write input stands for other bus masters. It takes the write path ahead of every port, and each write it makes is watched like any other. Every port holds at most one reservation: a valid bit and a granule number. Writes made by other ports or by the external agent into an armed granule disarm it. The port's interrupt input does not touch it. The granule size in words is a power-of-two parameter.

Top module: `atomic_resv_mem`

## Requirements
- R1: At most one port is granted per cycle, and it is the lowest-indexed requesting port. While `ext_wr_en` is high no port is granted.
- R2: Opcodes are 3 bits: load=0, store=1, LL=2, SC=3, line-zero=4. A request granted at a clock edge gets `rsp_valid` for exactly the following cycle, and for load and LL `rsp_rdata` carries the word held before that edge.
- R3: An LL returns the addressed word and arms the port's reservation on granule `addr >> log2(GRAN_WORDS)`. A following SC from that port to any word of the same granule writes its data and returns `rsp_sc_ok`=1.
- R4: An SC issued while the port has no armed reservation, or whose address lies in a different granule, returns `rsp_sc_ok`=0 and leaves memory unchanged.
- R5: Every SC disarms the issuing port's reservation, whether it passed or failed and whether its granule matched.
- R6: A new LL from a port replaces that port's earlier reservation.
- R7: A store or line-zero from another port into an armed granule disarms it. A store from the owning port, or a write to another granule, leaves it armed.
- R8: An external-agent write into an armed granule disarms it. An external write to another granule leaves it armed.
- R9: The interrupt inputs have no effect on any reservation.
- R10: A line-zero writes zero to all GRAN_WORDS words of the granule that holds its address and changes no other word.
- R11: When two ports issue SCs to the same armed granule in the same cycle, the lower-indexed port succeeds. Its write disarms the other reservation, so the other SC fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears memory and reservations |
| req_valid | input | NP | Per-port request, held until granted |
| req_op | input | NP*3 | Per-port opcode (R2 encoding) |
| req_addr | input | NP*ADDR_W | Per-port word address |
| req_wdata | input | NP*DATA_W | Per-port store / SC data |
| irq | input | NP | Per-port interrupt; has no effect on reservations |
| req_grant | output | NP | One-hot grant, same cycle as the request |
| rsp_valid | output | NP | Response strobe, one cycle after grant |
| rsp_rdata | output | NP*DATA_W | Read data for load and LL |
| rsp_sc_ok | output | NP | SC success flag, valid with `rsp_valid` |
| ext_wr_en | input | 1 | External-agent write strobe |
| ext_wr_addr | input | ADDR_W | External-agent word address |
| ext_wr_data | input | DATA_W | External-agent write data |

## Verification
The assertions check on every cycle that the grant is one-hot and goes to the lowest requester. They check that grants stop under an external write, that each response follows its grant by one cycle, that an LL always arms and an SC always disarms its port's slot, and that reservations stay still on any cycle without a grant or an external write, whatever the interrupts do. Whether a given SC should pass depends on the history of other ports' writes, so only the bench's scenarios can show it. The same holds for memory contents after a failed SC, the exact word range a line-zero clears, and the outcome of two competing SCs.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   localparam int unsigned OP_W = 3;
   typedef enum logic [OP_W-1:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_LL    = 3'd2,
      OP_SC    = 3'd3,
      OP_ZERO  = 3'd4
   } mem_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
   parameter int unsigned NP = 3,
   localparam int unsigned IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic             hold,
   input  logic [NP-1:0]    req,
   output logic [NP-1:0]    gnt,
   output logic [IDX_W-1:0] idx
);
   logic found;
   always_comb begin
      gnt   = '0;
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < int'(NP); i++) begin
         if (!hold && req[i] && !found) begin
            gnt[i] = 1'b1;
            idx    = IDX_W'(i);
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
   parameter int unsigned GRAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [GRAN_W-1:0] set_gran,
   input  logic              self_clr,
   input  logic              snoop_en,
   input  logic [GRAN_W-1:0] snoop_gran,
   output logic              valid,
   output logic [GRAN_W-1:0] gran
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         gran  <= '0;
      end else if (set_en) begin
         valid <= 1'b1;
         gran  <= set_gran;
      end else if (self_clr) begin
         valid <= 1'b0;
      end else if (snoop_en && valid && (snoop_gran == gran)) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned GRAN_WORDS = 4,
   localparam int unsigned DEPTH     = 1 << ADDR_W,
   localparam int unsigned OFS_W     = $clog2(GRAN_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_line,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < int'(DEPTH); w++) begin : g_word
      localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
      logic              hit_word;
      logic              hit_line;
      logic              we;
      logic [DATA_W-1:0] word_q;
      assign hit_word = (wr_addr == WA);
      assign hit_line = ((wr_addr >> OFS_W) == (WA >> OFS_W));
      assign we       = wr_en && (wr_line ? hit_line : hit_word);
      always_ff @(posedge clk) begin
         if (!rst_n)  word_q <= '0;
         else if (we) word_q <= wr_line ? '0 : wr_data;
      end
      assign words[w] = word_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= words[rd_addr];
   end
endmodule

// File: rtl/atomic_resv_mem.sv
module atomic_resv_mem
   import llsc_pkg::*;
#(
   parameter int unsigned NP         = 3,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned GRAN_WORDS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NP-1:0]        req_valid,
   input  logic [NP*OP_W-1:0]   req_op,
   input  logic [NP*ADDR_W-1:0] req_addr,
   input  logic [NP*DATA_W-1:0] req_wdata,
   input  logic [NP-1:0]        irq,
   output logic [NP-1:0]        req_grant,
   output logic [NP-1:0]        rsp_valid,
   output logic [NP*DATA_W-1:0] rsp_rdata,
   output logic [NP-1:0]        rsp_sc_ok,
   input  logic                 ext_wr_en,
   input  logic [ADDR_W-1:0]    ext_wr_addr,
   input  logic [DATA_W-1:0]    ext_wr_data
);
   localparam int unsigned OFS_W  = $clog2(GRAN_WORDS);
   localparam int unsigned GRAN_W = ADDR_W - OFS_W;
   localparam int unsigned IDX_W  = (NP > 1) ? $clog2(NP) : 1;

   // elaboration-time parameter checks
   if (NP < 1) begin : g_bad_np
      $error("NP must be at least 1");
   end
   if ((GRAN_WORDS == 0) || ((GRAN_WORDS & (GRAN_WORDS - 1)) != 0)) begin : g_bad_gran
      $error("GRAN_WORDS must be a power of two");
   end
   if (OFS_W >= ADDR_W) begin : g_bad_span
      $error("GRAN_WORDS must be smaller than the memory");
   end

   // interrupts are deliberately not connected to reservation logic
   logic irq_unused;
   assign irq_unused = ^irq;

   // per-port request lanes
   mem_op_e           op_a    [NP];
   logic [ADDR_W-1:0] addr_a  [NP];
   logic [DATA_W-1:0] wdata_a [NP];
   for (genvar p = 0; p < int'(NP); p++) begin : g_lane
      assign op_a[p]    = mem_op_e'(req_op[p*OP_W +: OP_W]);
      assign addr_a[p]  = req_addr[p*ADDR_W +: ADDR_W];
      assign wdata_a[p] = req_wdata[p*DATA_W +: DATA_W];
   end

   // arbitration: external writer first, then lowest port index
   logic [IDX_W-1:0] gidx;
   llsc_prio_arb #(.NP(NP)) u_arb (
      .hold (ext_wr_en),
      .req  (req_valid),
      .gnt  (req_grant),
      .idx  (gidx)
   );

   logic              any_gnt;
   mem_op_e           sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   assign any_gnt   = |req_grant;
   assign sel_op    = op_a[gidx];
   assign sel_addr  = addr_a[gidx];
   assign sel_wdata = wdata_a[gidx];

   // reservation slots
   logic [NP-1:0]     resv_vld;
   logic [GRAN_W-1:0] resv_gran [NP];
   logic              sc_pass;
   assign sc_pass = any_gnt && (sel_op == OP_SC) && resv_vld[gidx] &&
                    (resv_gran[gidx] == sel_addr[ADDR_W-1:OFS_W]);

   // single write path
   logic              wr_en;
   logic              wr_line;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   always_comb begin
      if (ext_wr_en) begin
         wr_en   = 1'b1;
         wr_line = 1'b0;
         wr_addr = ext_wr_addr;
         wr_data = ext_wr_data;
      end else begin
         wr_en   = any_gnt && ((sel_op == OP_STORE) || (sel_op == OP_ZERO) || sc_pass);
         wr_line = (sel_op == OP_ZERO);
         wr_addr = sel_addr;
         wr_data = sel_wdata;
      end
   end

   for (genvar p = 0; p < int'(NP); p++) begin : g_slot
      logic set_en;
      logic self_clr;
      logic snoop_en;
      assign set_en   = req_grant[p] && (op_a[p] == OP_LL);
      assign self_clr = req_grant[p] && (op_a[p] == OP_SC);
      assign snoop_en = wr_en && !req_grant[p];
      llsc_resv_slot #(.GRAN_W(GRAN_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_en     (set_en),
         .set_gran   (addr_a[p][ADDR_W-1:OFS_W]),
         .self_clr   (self_clr),
         .snoop_en   (snoop_en),
         .snoop_gran (wr_addr[ADDR_W-1:OFS_W]),
         .valid      (resv_vld[p]),
         .gran       (resv_gran[p])
      );
   end

   // storage
   logic [DATA_W-1:0] rd_data;
   llsc_word_mem #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .GRAN_WORDS (GRAN_WORDS)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_line (wr_line),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (sel_addr),
      .rd_data (rd_data)
   );

   // responses, one cycle after grant
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_sc_ok <= '0;
      end else begin
         rsp_valid <= req_grant;
         rsp_sc_ok <= req_grant & {NP{sc_pass}};
      end
   end

   for (genvar p = 0; p < int'(NP); p++) begin : g_rsp
      assign rsp_rdata[p*DATA_W +: DATA_W] = rsp_valid[p] ? rd_data : '0;
   end
endmodule

// File: rtl/atomic_resv_mem_chk.sv
module atomic_resv_mem_chk
   import llsc_pkg::*;
#(
   parameter int unsigned NP = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NP-1:0]      req_valid,
   input logic [NP*OP_W-1:0] req_op,
   input logic [NP-1:0]      req_grant,
   input logic [NP-1:0]      rsp_valid,
   input logic [NP-1:0]      rsp_sc_ok,
   input logic               ext_wr_en,
   input logic [NP-1:0]      resv_vld
);
   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant)); // R1
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |-> (((req_grant - 1'b1) & req_valid) == '0)); // R1
   AST_EXT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr_en |-> (req_grant == '0)); // R1
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_grant) |=> (rsp_valid == $past(req_grant))); // R2
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant == '0) |=> (rsp_valid == '0)); // R2
   AST_SC_FLAG_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_sc_ok & ~rsp_valid) == '0)); // R4
   AST_RESV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_grant == '0) && !ext_wr_en) |=> $stable(resv_vld)); // R9

   for (genvar p = 0; p < int'(NP); p++) begin : g_port
      AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
         (req_grant[p] && (req_op[p*OP_W +: OP_W] == OP_LL)) |=> resv_vld[p]); // R3
      AST_SC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
         (req_grant[p] && (req_op[p*OP_W +: OP_W] == OP_SC)) |=> !resv_vld[p]); // R5
   end
endmodule

bind atomic_resv_mem atomic_resv_mem_chk #(.NP(NP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_grant (req_grant),
   .rsp_valid (rsp_valid),
   .rsp_sc_ok (rsp_sc_ok),
   .ext_wr_en (ext_wr_en),
   .resv_vld  (resv_vld)
);

// File: tb/atomic_resv_mem_tb.sv
`timescale 1ns/1ps
module atomic_resv_mem_tb_top;
   import llsc_pkg::*;
   localparam int NP = 3;
   localparam int AW = 6;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   req_valid = '0;
   logic [NP*3-1:0] req_op = '0;
   logic [NP*AW-1:0] req_addr = '0;
   logic [NP*DW-1:0] req_wdata = '0;
   logic [NP-1:0]   irq = '0;
   logic [NP-1:0]   req_grant;
   logic [NP-1:0]   rsp_valid;
   logic [NP*DW-1:0] rsp_rdata;
   logic [NP-1:0]   rsp_sc_ok;
   logic            ext_wr_en = 1'b0;
   logic [AW-1:0]   ext_wr_addr = '0;
   logic [DW-1:0]   ext_wr_data = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   atomic_resv_mem #(.NP(NP), .ADDR_W(AW), .DATA_W(DW), .GRAN_WORDS(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .irq(irq),
      .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_sc_ok(rsp_sc_ok), .ext_wr_en(ext_wr_en), .ext_wr_addr(ext_wr_addr),
      .ext_wr_data(ext_wr_data)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic drive(input int p, input mem_op_e op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      req_valid[p]          = 1'b1;
      req_op[p*3 +: 3]      = op;
      req_addr[p*AW +: AW]  = a;
      req_wdata[p*DW +: DW] = d;
   endtask

   task automatic do_op(input int p, input mem_op_e op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic ok);
      int n = 0;
      @(negedge clk);
      drive(p, op, a, d);
      #1;
      while (!req_grant[p] && n < 100) begin
         @(negedge clk); #1; n++;
      end
      @(posedge clk);
      @(negedge clk);
      chk("R2 rsp_valid one cycle after grant", 32'(rsp_valid[p]), 32'd1);
      rd = rsp_rdata[p*DW +: DW];
      ok = rsp_sc_ok[p];
      req_valid[p] = 1'b0;
   endtask

   task automatic load_chk(input string rq, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      logic [DW-1:0] rd; logic ok;
      do_op(2, OP_LOAD, a, '0, rd, ok);
      chk(rq, rd, exp);
   endtask

   task automatic ext_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ext_wr_en = 1'b1; ext_wr_addr = a; ext_wr_data = d;
      @(negedge clk);
      ext_wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R2 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      chk("R1 no grant when idle", 32'(req_grant), 32'd0);
   endtask

   task automatic t_basic();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_STORE, 6'd5, 32'hA5, rd, ok);
      load_chk("R2 load returns stored word", 6'd5, 32'hA5);
   endtask

   task automatic t_llsc();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_STORE, 6'd9, 32'h11, rd, ok);
      do_op(0, OP_LL, 6'd9, '0, rd, ok);
      chk("R3 LL read data", rd, 32'h11);
      do_op(0, OP_SC, 6'd10, 32'h22, rd, ok);
      chk("R3 SC in same granule passes", 32'(ok), 32'd1);
      load_chk("R3 SC data committed", 6'd10, 32'h22);
   endtask

   task automatic t_sc_fail();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_SC, 6'd9, 32'h33, rd, ok);
      chk("R5 SC after successful SC fails", 32'(ok), 32'd0);
      load_chk("R4 failed SC leaves memory", 6'd9, 32'h11);
      do_op(0, OP_LL, 6'd9, '0, rd, ok);
      do_op(0, OP_SC, 6'd20, 32'h44, rd, ok);
      chk("R4 SC outside granule fails", 32'(ok), 32'd0);
      load_chk("R4 SC outside granule writes nothing", 6'd20, 32'h0);
      do_op(0, OP_SC, 6'd9, 32'h55, rd, ok);
      chk("R5 mismatched SC cleared reservation", 32'(ok), 32'd0);
      load_chk("R5 memory unchanged", 6'd9, 32'h11);
   endtask

   task automatic t_replace();
      logic [DW-1:0] rd; logic ok;
      do_op(1, OP_LL, 6'd12, '0, rd, ok);
      do_op(1, OP_LL, 6'd24, '0, rd, ok);
      do_op(1, OP_SC, 6'd12, 32'h1, rd, ok);
      chk("R6 old granule no longer reserved", 32'(ok), 32'd0);
      do_op(1, OP_LL, 6'd12, '0, rd, ok);
      do_op(1, OP_LL, 6'd24, '0, rd, ok);
      do_op(1, OP_SC, 6'd25, 32'h99, rd, ok);
      chk("R6 new granule reserved", 32'(ok), 32'd1);
   endtask

   task automatic t_foreign();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_LL, 6'd16, '0, rd, ok);
      do_op(1, OP_STORE, 6'd18, 32'h5, rd, ok);
      do_op(0, OP_SC, 6'd16, 32'h6, rd, ok);
      chk("R7 other port store cancels", 32'(ok), 32'd0);
      do_op(0, OP_LL, 6'd16, '0, rd, ok);
      do_op(0, OP_STORE, 6'd17, 32'h77, rd, ok);
      do_op(0, OP_SC, 6'd16, 32'h66, rd, ok);
      chk("R7 own store keeps reservation", 32'(ok), 32'd1);
      do_op(0, OP_LL, 6'd16, '0, rd, ok);
      do_op(2, OP_STORE, 6'd40, 32'h8, rd, ok);
      do_op(0, OP_SC, 6'd16, 32'h67, rd, ok);
      chk("R7 store to other granule keeps reservation", 32'(ok), 32'd1);
      do_op(0, OP_LL, 6'd16, '0, rd, ok);
      do_op(1, OP_ZERO, 6'd19, '0, rd, ok);
      do_op(0, OP_SC, 6'd16, 32'h68, rd, ok);
      chk("R7 other port line-zero cancels", 32'(ok), 32'd0);
   endtask

   task automatic t_ext();
      logic [DW-1:0] rd; logic ok;
      do_op(1, OP_LL, 6'd32, '0, rd, ok);
      ext_write(6'd35, 32'hE1);
      do_op(1, OP_SC, 6'd32, 32'h2, rd, ok);
      chk("R8 external write in granule cancels", 32'(ok), 32'd0);
      do_op(1, OP_LL, 6'd32, '0, rd, ok);
      ext_write(6'd36, 32'hE2);
      do_op(1, OP_SC, 6'd32, 32'h3, rd, ok);
      chk("R8 external write elsewhere keeps", 32'(ok), 32'd1);
      load_chk("R8 external data written", 6'd35, 32'hE1);
      // R1: external writer holds off a pending port
      @(negedge clk);
      ext_wr_en = 1'b1; ext_wr_addr = 6'd60; ext_wr_data = 32'hE3;
      drive(2, OP_LOAD, 6'd60, '0);
      #1;
      chk("R1 no grant during external write", 32'(req_grant), 32'd0);
      @(negedge clk);
      ext_wr_en = 1'b0;
      #1;
      chk("R1 grant resumes after external write", 32'(req_grant), 32'b100);
      @(posedge clk); @(negedge clk);
      chk("R1 held-off load sees external data", rsp_rdata[2*DW +: DW], 32'hE3);
      req_valid[2] = 1'b0;
   endtask

   task automatic t_irq();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_LL, 6'd8, '0, rd, ok);
      @(negedge clk); irq = 3'b111;
      repeat (3) @(negedge clk);
      irq = 3'b000;
      @(negedge clk); irq[0] = 1'b1;
      do_op(0, OP_SC, 6'd8, 32'hC0, rd, ok);
      irq = '0;
      chk("R9 interrupt leaves reservation", 32'(ok), 32'd1);
   endtask

   task automatic t_zero();
      logic [DW-1:0] rd; logic ok;
      for (int i = 43; i <= 48; i++) do_op(1, OP_STORE, AW'(i), 32'(i + 256), rd, ok);
      do_op(2, OP_ZERO, 6'd45, '0, rd, ok);
      for (int i = 44; i <= 47; i++) load_chk("R10 line word zeroed", AW'(i), 32'h0);
      load_chk("R10 word below line kept", 6'd43, 32'd299);
      load_chk("R10 word above line kept", 6'd48, 32'd304);
   endtask

   task automatic t_race();
      logic [DW-1:0] rd; logic ok;
      do_op(0, OP_LL, 6'd52, '0, rd, ok);
      do_op(1, OP_LL, 6'd52, '0, rd, ok);
      @(negedge clk);
      drive(0, OP_SC, 6'd53, 32'hAAAA);
      drive(1, OP_SC, 6'd53, 32'hBBBB);
      #1;
      chk("R1 lowest port granted first", 32'(req_grant), 32'b001);
      @(posedge clk); @(negedge clk);
      chk("R11 first SC passes", 32'(rsp_sc_ok[0]), 32'd1);
      req_valid[0] = 1'b0;
      #1;
      chk("R1 second port granted next", 32'(req_grant), 32'b010);
      @(posedge clk); @(negedge clk);
      chk("R11 second SC fails", 32'(rsp_sc_ok[1]), 32'd0);
      req_valid[1] = 1'b0;
      load_chk("R11 winner data in memory", 6'd53, 32'hAAAA);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_llsc();
      t_sc_fail();
      t_replace();
      t_foreign();
      t_ext();
      t_irq();
      t_zero();
      t_race();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule